// File: doc/BRIEF.md
# Prefixed-group rotate, shift and bit-manipulation unit

This unit carries out the second-byte operation group of an 8-bit processor that follows the bit-group prefix. It takes that opcode byte, the 8-bit operand already fetched by the core, the current flag byte, and a mode input that marks an indexed access. It returns the new byte, the new flag byte, and write strobes that tell the surrounding core where the byte must go: to memory, to a register named by the opcode, or to both.

The group holds eight rotates and shifts, including the shift that moves a one into bit 0, plus single-bit test, clear and set. In indexed mode the operation always works on the memory byte. When the operand field of the opcode names a register, the byte is also copied into that register. A bit test never produces a write in either mode.

A one-cycle `start` strobe captures all inputs. On the next cycle `valid` and the write strobes pulse for one cycle. The result, flags and register index then hold until the next `start`.

Top module: `bit_unit`

## Requirements
- R1: While reset is asserted, and afterwards until the first `start`, `valid`, `mem_we` and `reg_we` are low.
- R2: A `start` in one cycle makes `valid` high in the next cycle only. `mem_we` and `reg_we` are active only in that cycle. `result`, `flags_out` and `reg_idx` hold their values until the next `start`.
- R3: Opcode bits 7:6 select the group: 00 is rotate/shift, 01 is bit test, 10 is bit clear, 11 is bit set. Bits 2:0 name the operand slot: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory, 7 A. `reg_idx` always carries bits 2:0.
- R4: In the rotate/shift group, bits 5:3 = 0 to 3 select RLC, RRC, RL and RR. RLC and RRC rotate the byte and copy the bit that leaves into carry. RL and RR rotate through the carry flag.
- R5: Bits 5:3 = 4, 5 and 7 select SLA (zero into bit 0), SRA (bit 7 kept) and SRL (zero into bit 7). The bit that leaves goes to carry.
- R6: Bits 5:3 = 6 selects the fill-one left shift. It shifts left, moves bit 7 into carry and sets bit 0 to one.
- R7: Flag bits are S=7, Z=6, H=4, P=2, N=1, C=0. For any rotate or shift, S is result bit 7, Z is set when the result is zero, P is set for even parity of the result, and H and N are cleared. Flag bits 5 and 3 always pass through from `flags_in`.
- R8: Bit test of bit n (bits 5:3) sets Z and P to the inverse of operand bit n. S is set only when n is 7 and that bit is one. H is set, N is cleared, C is kept. `result` equals the operand, and no write strobe is raised.
- R9: Bit clear and bit set change only bit n of the operand, and `flags_out` equals `flags_in`.
- R10: Outside indexed mode, a writing operation raises `mem_we` alone for slot 6 and `reg_we` alone for any other slot.
- R11: In indexed mode, every writing operation raises `mem_we`. It also raises `reg_we` when the slot is not 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the inputs and run one operation |
| indexed | input | 1 | Operand is an indexed memory byte |
| opcode | input | 8 | Second opcode byte of the group |
| operand | input | 8 | Operand byte fetched by the core |
| flags_in | input | 8 | Current flag byte |
| valid | output | 1 | One-cycle pulse when the outputs are new |
| result | output | 8 | Resulting byte |
| flags_out | output | 8 | Updated flag byte |
| mem_we | output | 1 | Write `result` to the memory operand |
| reg_we | output | 1 | Write `result` to register `reg_idx` |
| reg_idx | output | 3 | Register slot from opcode bits 2:0 |

## Verification
Several rules are checked by assertions on every cycle. A bit test never raises a write strobe. An indexed write always reaches memory. A register strobe never names the memory slot. Clear and set leave the flags untouched. The fill-one shift always leaves bit 0 set. The one-cycle response and the holding of outputs between strobes are also checked each cycle. Only the bench's vectors can show the exact rotated and shifted values, the carry that leaves each shift, the parity flag, and the chosen target register. They also cover the test flags for bit 7 against a low bit, and the passing of flag bits 5 and 3.

// File: rtl/bitu_pkg.sv
package bitu_pkg;
  localparam int DW    = 8;
  localparam int SLOTW = 3;
  localparam int FLG_S = 7;
  localparam int FLG_Z = 6;
  localparam int FLG_H = 4;
  localparam int FLG_P = 2;
  localparam int FLG_N = 1;
  localparam int FLG_C = 0;
  localparam logic [SLOTW-1:0] MEM_SLOT = 3'd6;
  localparam logic [SLOTW-1:0] TOP_BIT  = SLOTW'(DW - 1);

  typedef enum logic [1:0] {GRP_ROT, GRP_TEST, GRP_CLR, GRP_PUT} grp_e;
  typedef enum logic [2:0] {
    SH_RLC, SH_RRC, SH_RL, SH_RR, SH_SLA, SH_SRA, SH_SLS, SH_SRL
  } shop_e;

  typedef struct packed {
    logic          cout;
    logic [DW-1:0] val;
  } shres_t;

  function automatic logic even_par(input logic [DW-1:0] v);
    return ~^v;
  endfunction

  function automatic logic [DW-1:0] bit_mask(input logic [SLOTW-1:0] n);
    return DW'(1) << n;
  endfunction

  function automatic shres_t shift_calc(input shop_e op, input logic [DW-1:0] v,
                                        input logic cin);
    shres_t r;
    case (op)
      SH_RLC:  r = {v[DW-1], v[DW-2:0], v[DW-1]};
      SH_RRC:  r = {v[0], v[0], v[DW-1:1]};
      SH_RL:   r = {v[DW-1], v[DW-2:0], cin};
      SH_RR:   r = {v[0], cin, v[DW-1:1]};
      SH_SLA:  r = {v[DW-1], v[DW-2:0], 1'b0};
      SH_SRA:  r = {v[0], v[DW-1], v[DW-1:1]};
      SH_SLS:  r = {v[DW-1], v[DW-2:0], 1'b1};
      default: r = {v[0], 1'b0, v[DW-1:1]};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bitu_decode.sv
module bitu_decode
  import bitu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    opcode,
  input  logic             indexed,
  output grp_e             grp,
  output shop_e            shop,
  output logic [SLOTW-1:0] bitno,
  output logic [SLOTW-1:0] slot,
  output logic             wr_mem,
  output logic             wr_reg
);
  logic writes;
  logic slot_is_mem;

  assign grp         = grp_e'(opcode[7:6]);
  assign shop        = shop_e'(opcode[5:3]);
  assign bitno       = opcode[5:3];
  assign slot        = opcode[2:0];
  assign writes      = (grp != GRP_TEST);
  assign slot_is_mem = (slot == MEM_SLOT);
  assign wr_mem      = writes && (indexed || slot_is_mem);
  assign wr_reg      = writes && !slot_is_mem;

  // R8
  test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp == GRP_TEST) |-> (!wr_mem && !wr_reg));

  // R11
  indexed_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (indexed && opcode[7:6] != 2'b01) |-> wr_mem);

  // R10
  reg_not_mem_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reg |-> (opcode[2:0] != 3'd6));
endmodule

// File: rtl/bitu_alu.sv
module bitu_alu
  import bitu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  grp_e             grp,
  input  shop_e            shop,
  input  logic [SLOTW-1:0] bitno,
  input  logic [DW-1:0]    operand,
  input  logic [DW-1:0]    flags_in,
  output logic [DW-1:0]    res,
  output logic [DW-1:0]    flg
);
  shres_t        sh;
  logic [DW-1:0] mask;
  logic          tested;

  assign sh     = shift_calc(shop, operand, flags_in[FLG_C]);
  assign mask   = bit_mask(bitno);
  assign tested = |(operand & mask);

  always_comb begin
    res = operand;
    flg = flags_in;
    case (grp)
      GRP_ROT: begin
        res        = sh.val;
        flg[FLG_S] = sh.val[DW-1];
        flg[FLG_Z] = (sh.val == '0);
        flg[FLG_H] = 1'b0;
        flg[FLG_P] = even_par(sh.val);
        flg[FLG_N] = 1'b0;
        flg[FLG_C] = sh.cout;
      end
      GRP_TEST: begin
        flg[FLG_S] = tested && (bitno == TOP_BIT);
        flg[FLG_Z] = ~tested;
        flg[FLG_H] = 1'b1;
        flg[FLG_P] = ~tested;
        flg[FLG_N] = 1'b0;
      end
      GRP_CLR: res = operand & ~mask;
      default: res = operand | mask;
    endcase
  end

  // R9
  modify_flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp == GRP_CLR || grp == GRP_PUT) |-> (flg == flags_in));

  // R6
  fill_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp == GRP_ROT && shop == SH_SLS) |-> (res[0] && flg[FLG_C] == operand[DW-1]));

  // R8
  test_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp == GRP_TEST) |-> (res == operand && flg[FLG_C] == flags_in[FLG_C] && flg[FLG_H]));
endmodule

// File: rtl/bit_unit.sv
module bit_unit
  import bitu_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         indexed,
  input  logic [7:0]   opcode,
  input  logic [7:0]   operand,
  input  logic [7:0]   flags_in,
  output logic         valid,
  output logic [7:0]   result,
  output logic [7:0]   flags_out,
  output logic         mem_we,
  output logic         reg_we,
  output logic [2:0]   reg_idx
);
  logic [DW-1:0]    cap_op, cap_val, cap_flg;
  logic             cap_ix, valid_q;
  grp_e             grp;
  shop_e            shop;
  logic [SLOTW-1:0] bitno, slot;
  logic             wr_mem, wr_reg;
  logic [DW-1:0]    alu_res, alu_flg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_op  <= '0;
      cap_val <= '0;
      cap_flg <= '0;
      cap_ix  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= start;
      if (start) begin
        cap_op  <= opcode;
        cap_val <= operand;
        cap_flg <= flags_in;
        cap_ix  <= indexed;
      end
    end
  end

  bitu_decode u_dec (
    .clk(clk), .rst_n(rst_n), .opcode(cap_op), .indexed(cap_ix),
    .grp(grp), .shop(shop), .bitno(bitno), .slot(slot),
    .wr_mem(wr_mem), .wr_reg(wr_reg)
  );

  bitu_alu u_alu (
    .clk(clk), .rst_n(rst_n), .grp(grp), .shop(shop), .bitno(bitno),
    .operand(cap_val), .flags_in(cap_flg), .res(alu_res), .flg(alu_flg)
  );

  assign valid     = valid_q;
  assign result    = alu_res;
  assign flags_out = alu_flg;
  assign mem_we    = valid_q && wr_mem;
  assign reg_we    = valid_q && wr_reg;
  assign reg_idx   = slot;

  // R2
  start_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);

  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!valid && !mem_we && !reg_we && $stable(result) && $stable(flags_out)));

  // R3
  reg_strobe_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_idx != 3'd6 && valid));
endmodule

// File: tb/sim_bit_unit.sv
module sim_bit_unit;
  localparam time CLK_P = 20ns;

  typedef struct packed {
    logic [3:0] rq;
    logic       ix;
    logic [7:0] op, val, fin, eres, eflg;
    logic       emem, ereg;
    logic [2:0] eidx;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  1'b0, 8'h00, 8'h81, 8'h00, 8'h03, 8'h05, 1'b0, 1'b1, 3'd0}, // RLC B
    '{4'd4,  1'b0, 8'h09, 8'h01, 8'h00, 8'h80, 8'h81, 1'b0, 1'b1, 3'd1}, // RRC C
    '{4'd4,  1'b0, 8'h12, 8'h80, 8'h01, 8'h01, 8'h01, 1'b0, 1'b1, 3'd2}, // RL D
    '{4'd4,  1'b0, 8'h1B, 8'h01, 8'h00, 8'h00, 8'h45, 1'b0, 1'b1, 3'd3}, // RR E
    '{4'd5,  1'b0, 8'h24, 8'h40, 8'h01, 8'h80, 8'h80, 1'b0, 1'b1, 3'd4}, // SLA H
    '{4'd5,  1'b0, 8'h2D, 8'h81, 8'h00, 8'hC0, 8'h85, 1'b0, 1'b1, 3'd5}, // SRA L
    '{4'd6,  1'b0, 8'h37, 8'h80, 8'h00, 8'h01, 8'h01, 1'b0, 1'b1, 3'd7}, // fill-one A
    '{4'd10, 1'b0, 8'h3E, 8'h01, 8'h10, 8'h00, 8'h45, 1'b1, 1'b0, 3'd6}, // SRL mem
    '{4'd8,  1'b0, 8'h58, 8'h00, 8'h01, 8'h00, 8'h55, 1'b0, 1'b0, 3'd0}, // test 3
    '{4'd8,  1'b0, 8'h7F, 8'h80, 8'h02, 8'h80, 8'h90, 1'b0, 1'b0, 3'd7}, // test 7
    '{4'd9,  1'b0, 8'h81, 8'hFF, 8'hD7, 8'hFE, 8'hD7, 1'b0, 1'b1, 3'd1}, // clear 0
    '{4'd9,  1'b0, 8'hFE, 8'h00, 8'h00, 8'h80, 8'h00, 1'b1, 1'b0, 3'd6}, // set 7 mem
    '{4'd11, 1'b1, 8'h00, 8'h81, 8'h00, 8'h03, 8'h05, 1'b1, 1'b1, 3'd0}, // ix RLC copy
    '{4'd11, 1'b1, 8'hD6, 8'h00, 8'h28, 8'h04, 8'h28, 1'b1, 1'b0, 3'd6}, // ix set 2
    '{4'd11, 1'b1, 8'h43, 8'h01, 8'h00, 8'h01, 8'h10, 1'b0, 1'b0, 3'd3}, // ix test 0
    '{4'd11, 1'b1, 8'hAD, 8'hFF, 8'h00, 8'hDF, 8'h00, 1'b1, 1'b1, 3'd5}, // ix clear 5
    '{4'd7,  1'b0, 8'h20, 8'h00, 8'h29, 8'h00, 8'h6C, 1'b0, 1'b1, 3'd0}  // SLA, 5/3 kept
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, indexed = 1'b0;
  logic [7:0] opcode = '0, operand = '0, flags_in = '0;
  logic valid, mem_we, reg_we;
  logic [7:0] result, flags_out;
  logic [2:0] reg_idx;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  bit_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .indexed(indexed),
    .opcode(opcode), .operand(operand), .flags_in(flags_in),
    .valid(valid), .result(result), .flags_out(flags_out),
    .mem_we(mem_we), .reg_we(reg_we), .reg_idx(reg_idx)
  );

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic ix, input logic [7:0] op, input logic [7:0] val,
                       input logic [7:0] fin);
    @(negedge clk);
    start = 1'b1; indexed = ix; opcode = op; operand = val; flags_in = fin;
    @(negedge clk);
    start = 1'b0; indexed = 1'b0; opcode = 8'hFF; operand = 8'h5A; flags_in = 8'hFF;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", {7'd0, valid}, 8'h00);
    chk("R1", "strobes in reset", {6'd0, mem_we, reg_we}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "strobes after reset", {5'd0, valid, mem_we, reg_we}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].ix, VECS[i].op, VECS[i].val, VECS[i].fin);
      chk("R2", "valid pulse", {7'd0, valid}, 8'h01);
      chk(tag(VECS[i].rq), $sformatf("result v%0d", i), result, VECS[i].eres);
      chk(tag(VECS[i].rq), $sformatf("flags v%0d", i), flags_out, VECS[i].eflg);
      chk(tag(VECS[i].rq), $sformatf("strobes v%0d", i), {6'd0, mem_we, reg_we},
          {6'd0, VECS[i].emem, VECS[i].ereg});
      chk("R3", $sformatf("reg_idx v%0d", i), {5'd0, reg_idx}, {5'd0, VECS[i].eidx});
    end

    // R2: after the pulse, strobes drop and outputs hold while inputs change
    @(negedge clk);
    chk("R2", "valid dropped", {7'd0, valid}, 8'h00);
    chk("R2", "strobes dropped", {6'd0, mem_we, reg_we}, 8'h00);
    chk("R2", "result held", result, 8'h00);
    chk("R2", "flags held", flags_out, 8'h6C);
    repeat (3) @(negedge clk);
    chk("R2", "result still held", result, 8'h00);

    // R3: set 1 on slot C vs slot A picks the register from bits 2:0
    issue(1'b0, 8'hCF, 8'h00, 8'h00);
    chk("R3", "set 1 A result", result, 8'h02);
    chk("R3", "set 1 A idx", {5'd0, reg_idx}, 8'h07);
    // R5: SRL on register drops bit 0 into carry, zero into bit 7
    issue(1'b0, 8'h38, 8'hFF, 8'h00);
    chk("R5", "SRL result", result, 8'h7F);
    chk("R5", "SRL flags", flags_out, 8'h01);
    // R6: fill-one on zero gives 01, carry clear
    issue(1'b0, 8'h30, 8'h00, 8'h01);
    chk("R6", "fill-one zero", result, 8'h01);
    chk("R6", "fill-one flags", flags_out, 8'h00);
    // R11: indexed op on slot 6 writes memory only
    issue(1'b1, 8'h06, 8'h01, 8'h00);
    chk("R11", "ix mem slot strobes", {6'd0, mem_we, reg_we}, 8'h02);
    // R10: back-to-back starts both respond
    @(negedge clk);
    start = 1'b1; opcode = 8'h80; operand = 8'h01; flags_in = 8'h00;
    @(negedge clk);
    opcode = 8'hC6; operand = 8'h00;
    chk("R10", "first of pair", result, 8'h00);
    @(negedge clk);
    start = 1'b0;
    chk("R10", "second of pair", result, 8'h01);
    chk("R10", "second strobes", {5'd0, valid, mem_we, reg_we}, 8'h06);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule